// File: doc/BRIEF.md
# Carved Resource Pool Allocator with Per-Connection Flow Control

This block guards a transport engine's on-chip entries (packet buffers and state contexts). It splits them into four separate pools, one for each combination of direction (transmit or receive) and transaction role (request or response). A steady stream of requests in one pool therefore cannot use up the entries that responses need. Each pool has a shared region and a small reserve. The reserve is kept for head-of-line traffic, so that a stalled queue can always advance.

The engine issues one operation per cycle: an allocation or a release. Each operation carries a pool selector, a head-of-line flag and a connection index. One cycle later the block reports whether the operation was granted, and whether the entry came from the reserve. The block also counts how many entries each connection holds, across all pools. It raises a per-connection stop signal to the upper layer when that count goes above a threshold. The threshold moves with the free space left in the shared regions, scaled by a power-of-two factor that software sets. The stop signal drops again once the count falls clearly below the threshold.

Top module: `pool_guard`

## Requirements
- R1: The pool index is {op_dir, op_rsp}: 0 is transmit request, 1 is transmit response, 2 is receive request, 3 is receive response. An allocation draws only from its own pool, so a full pool does not stop grants from another pool.
- R2: A normal allocation (op_hol=0) is granted exactly when its pool's shared region has fewer than SHARED_DEPTH entries in use. Otherwise it is refused and changes no state.
- R3: A head-of-line allocation takes from the shared region while the shared region has room, and reports done_from_reserve=0. It takes from the reserve, and reports done_from_reserve=1, only when the shared region is full.
- R4: A head-of-line allocation is refused when both the shared region and the reserve (HOL_DEPTH entries) of its pool are full.
- R5: A release refills the pool's reserve first while any reserve entry is in use. Only after that does it return an entry to the shared region.
- R6: A connection's usage count goes up by one on each granted allocation and down by one on each accepted release, whatever the pool.
- R7: A release for a connection whose usage is zero sets free_underflow=1 and done_granted=0, and leaves every pool and count unchanged.
- R8: The threshold is F shifted by alpha_shift, where F is the total free shared entries over all four pools. alpha_shift is 3-bit two's complement: 0..3 shifts left, -1..-3 shifts right, and -4 acts as -3.
- R9: One cycle after a connection's usage is strictly above the threshold, its xoff bit is 1.
- R10: A set xoff bit clears one cycle after usage + 2 is strictly below the threshold. Between the two limits it holds its value.
- R11: done_valid is 1 in the cycle after each operation and 0 otherwise. The result outputs are registered.
- R12: After reset all pools are empty, all usage counts are zero, xoff is all zero and no result is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_free | input | 1 | 1 = release, 0 = allocate |
| op_dir | input | 1 | 0 = transmit, 1 = receive |
| op_rsp | input | 1 | 0 = request pool, 1 = response pool |
| op_hol | input | 1 | Allocation is for a head-of-line packet |
| op_conn | input | CONN_W | Connection index |
| alpha_shift | input | 3 | Signed power-of-two threshold factor |
| done_valid | output | 1 | Result of last cycle's operation is valid |
| done_granted | output | 1 | Allocation granted or release accepted |
| done_from_reserve | output | 1 | Granted entry came from the head-of-line reserve |
| free_underflow | output | 1 | Release for a connection holding nothing |
| xoff | output | NUM_CONN | Per-connection stop signal (0 = go) |

## Verification
The bound checker watches several rules on every cycle. It checks that occupancy never exceeds a pool's shared or reserve depth, and that a reserve grant is always also a grant. It checks that every xoff rise follows a count above the threshold, that every xoff fall follows a count below the hysteresis band, and that a release from an empty connection is always flagged. Some behaviours can only be shown by the bench's scenarios. These are the order in which the shared region and the reserve are used, the reserve-first refill on release, the isolation between pools, and the threshold value for each of the eight factor codes. The bench shows them by filling and draining each pool and by sweeping the factor while it checks every result and the whole xoff vector against an arithmetic model.

// File: rtl/pool_guard_pkg.sv
// Shared definitions for the carved pool allocator.
// Assumes exactly four pools, indexed by {direction, role}.
package pool_guard_pkg;
    localparam int NUM_CLASS = 4;
    localparam int CLASS_W   = 2;

    typedef enum logic [CLASS_W-1:0] {
        POOL_TX_REQ = 2'd0,
        POOL_TX_RSP = 2'd1,
        POOL_RX_REQ = 2'd2,
        POOL_RX_RSP = 2'd3
    } pool_sel_e;

    // Map direction and role bits onto a pool selector.
    function automatic pool_sel_e pool_of(input logic dir, input logic rsp);
        return pool_sel_e'({dir, rsp});
    endfunction
endpackage

// File: rtl/pool_guard_class.sv
// One carved pool: a shared region plus a head-of-line reserve.
// Assumes at most one of alloc_req / free_req per cycle and HOL_DEPTH >= 1.
// A release always refills the reserve before the shared region.
module pool_guard_class #(
    parameter int SHARED_DEPTH = 8,
    parameter int HOL_DEPTH    = 2,
    localparam int SH_W = $clog2(SHARED_DEPTH + 1),
    localparam int RS_W = $clog2(HOL_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_req,
    input  logic            hol_req,
    input  logic            free_req,
    output logic            alloc_ok,
    output logic            alloc_resv,
    output logic [SH_W-1:0] shared_used,
    output logic [RS_W-1:0] resv_used
);
    logic shared_room;
    logic resv_room;

    // Decide whether an allocation fits and which region serves it.
    always_comb begin
        shared_room = shared_used < SH_W'(SHARED_DEPTH);
        resv_room   = resv_used < RS_W'(HOL_DEPTH);
        alloc_ok    = alloc_req && (shared_room || (hol_req && resv_room));
        alloc_resv  = alloc_req && !shared_room && hol_req && resv_room;
    end

    // Track occupancy of both regions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shared_used <= '0;
            resv_used   <= '0;
        end else if (alloc_ok) begin
            if (alloc_resv) resv_used   <= resv_used + 1'b1;
            else            shared_used <= shared_used + 1'b1;
        end else if (free_req) begin
            if (resv_used != '0)        resv_used   <= resv_used - 1'b1;
            else if (shared_used != '0) shared_used <= shared_used - 1'b1;
        end
    end
endmodule

// File: rtl/pool_guard_thresh.sv
// Dynamic threshold: total free shared entries scaled by 2**alpha.
// alpha_shift is 3-bit two's complement; code -4 is treated as -3.
module pool_guard_thresh #(
    parameter int FREE_W = 6,
    localparam int THR_W = FREE_W + 3
) (
    input  logic [FREE_W-1:0] free_total,
    input  logic [2:0]        alpha_shift,
    output logic [THR_W-1:0]  thr
);
    logic [2:0] neg_mag;
    logic [1:0] right_amt;

    // Shift left for non-negative codes, right otherwise.
    always_comb begin
        neg_mag   = 3'd0 - alpha_shift;
        right_amt = (alpha_shift == 3'b100) ? 2'd3 : neg_mag[1:0];
        if (!alpha_shift[2]) thr = THR_W'(free_total) << alpha_shift[1:0];
        else                 thr = THR_W'(free_total) >> right_amt;
    end
endmodule

// File: rtl/pool_guard_conn.sv
// Per-connection usage counter with a hysteretic stop flag.
// Assumes dec is only raised when usage is non-zero (the top checks this).
module pool_guard_conn #(
    parameter int CNT_W = 8,
    parameter int THR_W = 9,
    parameter int HYST  = 2,
    localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic [THR_W-1:0] thr,
    output logic [CNT_W-1:0] usage,
    output logic             xoff
);
    logic above;
    logic below;

    // Compare usage against the threshold and its hysteresis floor.
    always_comb begin
        above = CMP_W'(usage) > CMP_W'(thr);
        below = (CMP_W'(usage) + CMP_W'(HYST)) < CMP_W'(thr);
    end

    // Count entries held by this connection.
    always_ff @(posedge clk) begin
        if (!rst_n)                     usage <= '0;
        else if (inc && usage != '1)    usage <= usage + 1'b1;
        else if (dec && usage != '0)    usage <= usage - 1'b1;
    end

    // Set stop above the threshold, clear below the floor, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     xoff <= 1'b0;
        else if (above) xoff <= 1'b1;
        else if (below) xoff <= 1'b0;
    end
endmodule

// File: rtl/pool_guard.sv
// Carved resource pool allocator with per-connection backpressure.
// One operation per cycle; results are registered and appear next cycle.
// Assumes NUM_CONN is a power of two so every op_conn value is in range.
module pool_guard
    import pool_guard_pkg::*;
#(
    parameter int NUM_CONN     = 16,
    parameter int CNT_W        = 8,
    parameter int SHARED_DEPTH = 8,
    parameter int HOL_DEPTH    = 2,
    parameter int HYST         = 2,
    localparam int CONN_W = $clog2(NUM_CONN),
    localparam int SH_W   = $clog2(SHARED_DEPTH + 1),
    localparam int RS_W   = $clog2(HOL_DEPTH + 1),
    localparam int FREE_W = $clog2(NUM_CLASS * SHARED_DEPTH + 1),
    localparam int THR_W  = FREE_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic                op_free,
    input  logic                op_dir,
    input  logic                op_rsp,
    input  logic                op_hol,
    input  logic [CONN_W-1:0]   op_conn,
    input  logic [2:0]          alpha_shift,
    output logic                done_valid,
    output logic                done_granted,
    output logic                done_from_reserve,
    output logic                free_underflow,
    output logic [NUM_CONN-1:0] xoff
);
    pool_sel_e                              sel;
    logic                                   underflow;
    logic [NUM_CLASS-1:0]                   cls_ok;
    logic [NUM_CLASS-1:0]                   cls_resv;
    logic [NUM_CLASS-1:0][SH_W-1:0]         sh_used_vec;
    logic [NUM_CLASS-1:0][RS_W-1:0]         rs_used_vec;
    logic [NUM_CONN-1:0][CNT_W-1:0]         usage_vec;
    logic [FREE_W-1:0]                      free_total;
    logic [THR_W-1:0]                       thr;

    // Decode the pool and detect a release from an empty connection.
    always_comb begin
        sel       = pool_of(op_dir, op_rsp);
        underflow = op_valid && op_free && (usage_vec[op_conn] == '0);
    end

    // Instantiate one carved pool per class.
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_pool
        logic hit;
        assign hit = op_valid && (sel == pool_sel_e'(c));
        pool_guard_class #(
            .SHARED_DEPTH(SHARED_DEPTH),
            .HOL_DEPTH   (HOL_DEPTH)
        ) pool_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_req  (hit && !op_free),
            .hol_req    (op_hol),
            .free_req   (hit && op_free && !underflow),
            .alloc_ok   (cls_ok[c]),
            .alloc_resv (cls_resv[c]),
            .shared_used(sh_used_vec[c]),
            .resv_used  (rs_used_vec[c])
        );
    end

    // Sum the free shared entries across all pools.
    always_comb begin
        free_total = '0;
        for (int c = 0; c < NUM_CLASS; c++)
            free_total = free_total + FREE_W'(SHARED_DEPTH) - FREE_W'(sh_used_vec[c]);
    end

    pool_guard_thresh #(.FREE_W(FREE_W)) thresh_i (
        .free_total (free_total),
        .alpha_shift(alpha_shift),
        .thr        (thr)
    );

    // Instantiate one usage tracker per connection.
    for (genvar i = 0; i < NUM_CONN; i++) begin : g_conn
        logic mine;
        assign mine = op_valid && (op_conn == CONN_W'(i));
        pool_guard_conn #(
            .CNT_W(CNT_W),
            .THR_W(THR_W),
            .HYST (HYST)
        ) conn_i (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (mine && !op_free && cls_ok[sel]),
            .dec  (mine && op_free && !underflow),
            .thr  (thr),
            .usage(usage_vec[i]),
            .xoff (xoff[i])
        );
    end

    // Register the per-operation result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid        <= 1'b0;
            done_granted      <= 1'b0;
            done_from_reserve <= 1'b0;
            free_underflow    <= 1'b0;
        end else begin
            done_valid        <= op_valid;
            done_granted      <= op_valid && (op_free ? !underflow : cls_ok[sel]);
            done_from_reserve <= op_valid && !op_free && cls_resv[sel];
            free_underflow    <= underflow;
        end
    end
endmodule

// File: rtl/pool_guard_chk.sv
// Checker for pool_guard: occupancy bounds, result flags and stop-flag causes.
module pool_guard_chk #(
    parameter int NUM_CONN  = 16,
    parameter int CNT_W     = 8,
    parameter int NUM_CLASS = 4,
    parameter int SH_W      = 4,
    parameter int RS_W      = 2,
    parameter int THR_W     = 9,
    parameter int SHARED_DEPTH = 8,
    parameter int HOL_DEPTH = 2,
    parameter int HYST      = 2,
    localparam int CONN_W   = $clog2(NUM_CONN)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           op_valid,
    input logic                           op_free,
    input logic [CONN_W-1:0]              op_conn,
    input logic                           done_valid,
    input logic                           done_granted,
    input logic                           done_from_reserve,
    input logic                           free_underflow,
    input logic [NUM_CONN-1:0]            xoff,
    input logic [NUM_CONN-1:0][CNT_W-1:0] usage_vec,
    input logic [THR_W-1:0]               thr,
    input logic [NUM_CLASS-1:0][SH_W-1:0] sh_used_vec,
    input logic [NUM_CLASS-1:0][RS_W-1:0] rs_used_vec
);
    // R11
    result_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done_valid);
    // R11
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done_valid);
    // R3
    reserve_implies_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_from_reserve |-> done_granted);
    // R7
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_free && usage_vec[op_conn] == '0) |=> (free_underflow && !done_granted));

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        // R2
        shared_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(sh_used_vec[c]) <= SHARED_DEPTH);
        // R4
        reserve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(rs_used_vec[c]) <= HOL_DEPTH);
    end

    for (genvar i = 0; i < NUM_CONN; i++) begin : g_cn
        // R9
        xoff_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(xoff[i]) |-> (32'($past(usage_vec[i])) > 32'($past(thr))));
        // R10
        xoff_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(xoff[i]) |-> ((32'($past(usage_vec[i])) + 32'(HYST)) < 32'($past(thr))));
    end
endmodule

bind pool_guard pool_guard_chk #(
    .NUM_CONN    (NUM_CONN),
    .CNT_W       (CNT_W),
    .NUM_CLASS   (pool_guard_pkg::NUM_CLASS),
    .SH_W        (SH_W),
    .RS_W        (RS_W),
    .THR_W       (THR_W),
    .SHARED_DEPTH(SHARED_DEPTH),
    .HOL_DEPTH   (HOL_DEPTH),
    .HYST        (HYST)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .op_valid         (op_valid),
    .op_free          (op_free),
    .op_conn          (op_conn),
    .done_valid       (done_valid),
    .done_granted     (done_granted),
    .done_from_reserve(done_from_reserve),
    .free_underflow   (free_underflow),
    .xoff             (xoff),
    .usage_vec        (usage_vec),
    .thr              (thr),
    .sh_used_vec      (sh_used_vec),
    .rs_used_vec      (rs_used_vec)
);

// File: tb/pool_guard_tb_top.sv
`timescale 1ns/1ps
module pool_guard_tb_top;
    localparam int NC   = 16;
    localparam int SH   = 8;
    localparam int RS   = 2;
    localparam int HY   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0, op_free = 1'b0, op_dir = 1'b0, op_rsp = 1'b0, op_hol = 1'b0;
    logic [3:0]    op_conn = '0;
    logic [2:0]    alpha_shift = 3'd0;
    logic          done_valid, done_granted, done_from_reserve, free_underflow;
    logic [NC-1:0] xoff;

    int total = 0;
    int bad   = 0;
    int m_sh[4];
    int m_rv[4];
    int m_use[NC];
    bit m_xoff[NC];
    int m_alpha = 0;

    always #2.5 clk = ~clk;

    pool_guard dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_free(op_free),
        .op_dir(op_dir), .op_rsp(op_rsp), .op_hol(op_hol), .op_conn(op_conn),
        .alpha_shift(alpha_shift), .done_valid(done_valid), .done_granted(done_granted),
        .done_from_reserve(done_from_reserve), .free_underflow(free_underflow), .xoff(xoff)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8 R9 R10: model the stop flags from the arithmetic threshold.
    task automatic model_xoff();
        int ft = 0;
        int a;
        int thr;
        for (int c = 0; c < 4; c++) ft += SH - m_sh[c];
        a = (m_alpha == -4) ? -3 : m_alpha;
        thr = (a >= 0) ? (ft << a) : (ft >> (-a));
        for (int i = 0; i < NC; i++) begin
            if (m_use[i] > thr)           m_xoff[i] = 1'b1;
            else if (m_use[i] + HY < thr) m_xoff[i] = 1'b0;
        end
    endtask

    function automatic logic [NC-1:0] pack_xoff();
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) v[i] = m_xoff[i];
        return v;
    endfunction

    // Issue one operation, check its result, then check the stop flags.
    task automatic op(input bit fr, input int cls, input bit hol, input int conn, input string tag);
        bit g;
        bit r;
        bit uf;
        @(negedge clk);
        op_valid = 1'b1; op_free = fr; op_dir = cls[1]; op_rsp = cls[0];
        op_hol = hol; op_conn = 4'(conn);
        @(negedge clk);
        op_valid = 1'b0;
        g = 0; r = 0; uf = 0;
        if (fr) begin
            uf = (m_use[conn] == 0);
            g  = !uf;
            if (!uf) begin
                m_use[conn]--;
                if (m_rv[cls] > 0)      m_rv[cls]--;
                else if (m_sh[cls] > 0) m_sh[cls]--;
            end
        end else begin
            if (m_sh[cls] < SH) begin
                g = 1; m_sh[cls]++;
            end else if (hol && m_rv[cls] < RS) begin
                g = 1; r = 1; m_rv[cls]++;
            end
            if (g) m_use[conn]++;
        end
        chk({tag, " R11 done_valid"}, 64'(done_valid), 64'd1);
        chk({tag, " R2 R6 done_granted"}, 64'(done_granted), 64'(g));
        chk({tag, " R3 done_from_reserve"}, 64'(done_from_reserve), 64'(r));
        chk({tag, " R7 free_underflow"}, 64'(free_underflow), 64'(uf));
        @(negedge clk);
        model_xoff();
        chk({tag, " R11 idle done_valid"}, 64'(done_valid), 64'd0);
        chk({tag, " R9 R10 xoff"}, 64'(xoff), 64'(pack_xoff()));
    endtask

    task automatic set_alpha(input int a);
        @(negedge clk);
        m_alpha = a;
        alpha_shift = 3'(a);
        @(negedge clk);
        model_xoff();
        chk($sformatf("R8 alpha=%0d xoff", a), 64'(xoff), 64'(pack_xoff()));
    endtask

    task automatic drain_all(input string tag);
        for (int i = 0; i < NC; i++)
            while (m_use[i] > 0) op(1'b1, (i % 4), 1'b0, i, tag);
    endtask

    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_sh[c] = 0; m_rv[c] = 0; end
        for (int i = 0; i < NC; i++) begin m_use[i] = 0; m_xoff[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        chk("R12 reset done_valid", 64'(done_valid), 64'd0);
        chk("R12 reset xoff", 64'(xoff), 64'd0);
        chk("R12 reset free_underflow", 64'(free_underflow), 64'd0);

        // R7: release from an empty connection.
        op(1'b1, 0, 1'b0, 3, "R7 empty release");

        // R1 R2 R3 R4 R5: fill and drain each carved pool.
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k <= SH; k++) op(1'b0, c, 1'b0, 4 * c + (k % 4), "R2 fill");
            op(1'b0, (c + 1) % 4, 1'b0, 15, "R1 other pool");
            op(1'b1, (c + 1) % 4, 1'b0, 15, "R1 other pool release");
            for (int k = 0; k <= RS; k++) op(1'b0, c, 1'b1, 4 * c, "R4 reserve");
            op(1'b1, c, 1'b0, 4 * c, "R5 refill reserve");
            op(1'b0, c, 1'b0, 4 * c + 1, "R5 shared still full");
            op(1'b0, c, 1'b1, 4 * c + 1, "R3 reserve regrant");
            drain_all("R6 drain");
            op(1'b1, c, 1'b0, 4 * c, "R7 after drain");
        end

        // R3: head-of-line allocation with room in shared region.
        op(1'b0, 2, 1'b1, 9, "R3 hol shared");
        op(1'b1, 2, 1'b0, 9, "R3 hol release");

        // R8 R9 R10: sweep every factor code while loading one connection.
        for (int a = -4; a <= 3; a++) begin
            set_alpha(a);
            for (int k = 0; k < 10; k++) op(1'b0, 1, 1'b0, 6, "R9 load");
            op(1'b0, 3, 1'b0, 7, "R9 second conn");
            for (int k = 0; k < 11; k++) op(1'b1, 1, 1'b0, 6, "R10 unload");
            drain_all("R10 drain");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule